// File: doc/BRIEF.md
# Switch register access bridge

This block lets a host processor reach the internal register file of a switch core. The register file is addressed by an 8-bit page and an 8-bit register number and holds values up to 64 bits wide. On the host side the block presents a small 32-bit register bus with an address, a write enable, write data and combinational read data. On the switch side it drives a request/acknowledge port that carries the page, the register number, a write flag and 64-bit write data, and takes back 64-bit read data.

Before it starts an access, the host asks for ownership through a request bit and waits for the grant bit. It then loads the two halves of the write data, if the access is a write. Next it writes a command word that holds the page, the register number, the direction and a go flag. It polls the go flag until the bridge clears it, and reads the two halves of the read data if the access was a read.

The host sizes each access. An 8-, 16- or 32-bit value lives in the low data word. A 48-bit value adds bits 15:0 of the high word, and a 64-bit value uses both words. The bridge always moves the full 64 bits.

The block also has these features:
- An abort when the switch does not answer within a programmable number of cycles.
- A soft reset bit that abandons an access in progress.
- A sticky capture register for event pulses from the switch, which drives one maskable host interrupt.

Top module: `swb_bridge`

## Requirements
- R1: A host write to byte offset 0x2C with bit 0 (go) set, bit 2 clear and grant held is accepted. From the next cycle `sw_req` is high, with `sw_page` taken from bits 31:24, `sw_regno` from bits 23:16 and `sw_write` from bit 1 (1 = write, 0 = read).
- R2: The bridge clears go in the cycle after `sw_ack` is seen with `sw_req` high, and `sw_req` drops at the same time. Offset 0x2C reads back page in 31:24, register in 23:16, timeout in bit 3, reset in bit 2, direction in bit 1 and go in bit 0.
- R3: Write data is held at 0x30 (bits 63:32) and 0x34 (bits 31:0) and is driven on `sw_wdata`. Read data appears at 0x38 (bits 63:32) and 0x3C (bits 31:0). It is loaded only when a read is acknowledged, and it holds across write accesses.
- R4: The control register at 0x40 holds the interrupt enable in bit 1 and the access request in bit 3, and both can be written. Bit 4 (grant) and bit 6 (`core_init_done`) are read-only. Grant rises one cycle after the request is seen while `core_init_done` is high, and falls one cycle after the request is cleared.
- R5: A command written while grant is not held is ignored, and so is a command written while go is still set. The go flag and the command fields are left unchanged.
- R6: The register at 0x44 latches every `evt_in` pulse into bits 12:0. Writing 1 to a bit clears it, and writing all ones clears all of them. A pulse arriving in the same cycle as a clear of that bit leaves the bit set.
- R7: `host_irq` is the OR of the latched event bits, gated by the interrupt enable bit of 0x40.
- R8: If `sw_ack` does not arrive, `sw_req` stays high for exactly `ack_timeout` cycles (`ack_timeout` must be 1 or more). Go then clears and bit 3 of 0x2C is set. Bit 3 stays set until the next accepted command or a reset.
- R9: Writing bit 2 of 0x2C drops `sw_req` in the next cycle. One cycle later the command register (including the timeout flag) and all four data registers are clear, and bit 2 itself reads 0.
- R10: A read of any offset that is not mapped returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hb_addr | input | 8 | Host byte address |
| hb_we | input | 1 | Host write enable |
| hb_wdata | input | 32 | Host write data |
| hb_rdata | output | 32 | Host read data for `hb_addr` |
| host_irq | output | 1 | Host interrupt |
| sw_req | output | 1 | Switch access request |
| sw_page | output | 8 | Register page |
| sw_regno | output | 8 | Register number within the page |
| sw_write | output | 1 | 1 = write, 0 = read |
| sw_wdata | output | 64 | Write value |
| sw_ack | input | 1 | Access done |
| sw_rdata | input | 64 | Read value, valid with `sw_ack` |
| core_init_done | input | 1 | Switch initialisation complete |
| ack_timeout | input | 16 | Cycles to wait for `sw_ack` |
| evt_in | input | 13 | Event pulses from the switch |

## Verification
The assertions assume that `sw_ack` is only raised while `sw_req` is high and that it falls again once the request drops. They also assume that `ack_timeout` is at least 1 and stays constant during an access. The bench's switch model raises acknowledge only on a pending request and holds it for a single cycle. Timeout changes are made only while no command is in flight. Event pulses are driven for one cycle from the negative edge, so that a capture and a clear can be placed in the same clock.

// File: rtl/swb_pkg.sv
package swb_pkg;
  localparam int PAGE_W = 8;
  localparam int REG_W  = 8;

  localparam logic [7:0] OFS_CMD = 8'h2C;
  localparam logic [7:0] OFS_WHI = 8'h30;
  localparam logic [7:0] OFS_WLO = 8'h34;
  localparam logic [7:0] OFS_RHI = 8'h38;
  localparam logic [7:0] OFS_RLO = 8'h3C;
  localparam logic [7:0] OFS_CTL = 8'h40;
  localparam logic [7:0] OFS_EVT = 8'h44;

  localparam int CMD_GO    = 0;
  localparam int CMD_WR    = 1;
  localparam int CMD_RST   = 2;
  localparam int CMD_TMO   = 3;
  localparam int CMD_REG0  = 16;
  localparam int CMD_PAGE0 = 24;

  localparam int CTL_IEN  = 1;
  localparam int CTL_REQ  = 3;
  localparam int CTL_GNT  = 4;
  localparam int CTL_INIT = 6;

  typedef struct packed {
    logic [PAGE_W-1:0] page;
    logic [REG_W-1:0]  regno;
    logic              wr;
  } swb_cmd_t;
endpackage

// File: rtl/swb_rst_sync.sv
module swb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/swb_own.sv
module swb_own (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_we,
  input  logic ctl_req_in,
  input  logic ctl_ien_in,
  input  logic init_done,
  output logic req_q,
  output logic ien_q,
  output logic grant_q
);
  logic req_d, ien_d, grant_d;

  always_comb begin
    req_d   = ctl_we ? ctl_req_in : req_q;
    ien_d   = ctl_we ? ctl_ien_in : ien_q;
    grant_d = req_q && init_done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      ien_q   <= 1'b0;
      grant_q <= 1'b0;
    end else begin
      req_q   <= req_d;
      ien_q   <= ien_d;
      grant_q <= grant_d;
    end
  end

  // R4
  grant_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_q |=> !grant_q);

  // R4
  grant_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && init_done) |=> grant_q);
endmodule

// File: rtl/swb_xfer.sv
module swb_xfer
  import swb_pkg::*;
#(
  parameter int TMO_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic              cmd_go,
  input  logic              cmd_rst,
  input  logic              cmd_wr,
  input  logic [PAGE_W-1:0] cmd_page,
  input  logic [REG_W-1:0]  cmd_regno,
  input  logic              grant,
  input  logic              sw_ack,
  input  logic [TMO_W-1:0]  limit,
  output logic              go_q,
  output logic              tmo_q,
  output logic              rst_q,
  output swb_cmd_t          cmd_q,
  output logic              rd_load
);
  logic [TMO_W-1:0] cnt_q, cnt_d;
  logic             go_d, tmo_d, rst_d;
  swb_cmd_t         cmd_d;
  logic             accept, fin, expire;

  assign accept = cmd_we && cmd_go && !cmd_rst && grant && !go_q && !rst_q;
  assign fin    = go_q && sw_ack && !rst_q;
  assign expire = go_q && !sw_ack && !rst_q &&
                  (({1'b0, cnt_q} + 1'b1) >= {1'b0, limit});

  always_comb begin
    go_d  = go_q;
    tmo_d = tmo_q;
    cmd_d = cmd_q;
    cnt_d = cnt_q;
    rst_d = 1'b0;
    if (rst_q) begin
      go_d  = 1'b0;
      tmo_d = 1'b0;
      cmd_d = '0;
      cnt_d = '0;
    end else begin
      rst_d = cmd_we && cmd_rst;
      if (accept) begin
        go_d  = 1'b1;
        tmo_d = 1'b0;
        cnt_d = '0;
        cmd_d = '{page: cmd_page, regno: cmd_regno, wr: cmd_wr};
      end else if (fin) begin
        go_d = 1'b0;
      end else if (expire) begin
        go_d  = 1'b0;
        tmo_d = 1'b1;
      end else if (go_q) begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_q  <= 1'b0;
      tmo_q <= 1'b0;
      rst_q <= 1'b0;
      cmd_q <= '0;
      cnt_q <= '0;
    end else begin
      go_q  <= go_d;
      tmo_q <= tmo_d;
      rst_q <= rst_d;
      cmd_q <= cmd_d;
      cnt_q <= cnt_d;
    end
  end

  assign rd_load = fin && !cmd_q.wr;

  // R2
  ack_clears_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go_q && sw_ack && !rst_q) |=> !go_q);

  // R5
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go_q && !rst_q) |=> $stable(cmd_q));

  // R8
  tmo_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_q) |-> !go_q);

  // R9
  rst_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |=> (!rst_q && !go_q && !tmo_q));
endmodule

// File: rtl/swb_evt.sv
module swb_evt #(
  parameter int EVT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] pulse,
  input  logic             clr_we,
  input  logic [EVT_W-1:0] clr_mask,
  input  logic             ien,
  output logic [EVT_W-1:0] pend_q,
  output logic             irq
);
  logic [EVT_W-1:0] pend_d;

  always_comb begin
    pend_d = pend_q;
    if (clr_we) pend_d = pend_d & ~clr_mask;
    pend_d = pend_d | pulse;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign irq = ien && (|pend_q);

  // R6
  evt_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse != '0) |=> ((pend_q & $past(pulse)) == $past(pulse)));

  // R6
  evt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
endmodule

// File: rtl/swb_bridge.sv
module swb_bridge
  import swb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BUS_W  = 32,
  parameter int TMO_W  = 16,
  parameter int EVT_W  = 13
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   hb_addr,
  input  logic                hb_we,
  input  logic [BUS_W-1:0]    hb_wdata,
  output logic [BUS_W-1:0]    hb_rdata,
  output logic                host_irq,
  output logic                sw_req,
  output logic [PAGE_W-1:0]   sw_page,
  output logic [REG_W-1:0]    sw_regno,
  output logic                sw_write,
  output logic [2*BUS_W-1:0]  sw_wdata,
  input  logic                sw_ack,
  input  logic [2*BUS_W-1:0]  sw_rdata,
  input  logic                core_init_done,
  input  logic [TMO_W-1:0]    ack_timeout,
  input  logic [EVT_W-1:0]    evt_in
);
  localparam int DATA_W = 2 * BUS_W;

  logic             rstn_i;
  logic             sel_cmd, sel_whi, sel_wlo, sel_ctl, sel_evt;
  logic             req_q, ien_q, grant_q;
  logic             go_q, tmo_q, rst_q, rd_load;
  swb_cmd_t         cmd_q;
  logic [EVT_W-1:0] pend_q;
  logic [BUS_W-1:0] whi_q, wlo_q, rhi_q, rlo_q;
  logic [BUS_W-1:0] whi_d, wlo_d, rhi_d, rlo_d;

  swb_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rstn_i));

  assign sel_cmd = hb_we && (hb_addr == ADDR_W'(OFS_CMD));
  assign sel_whi = hb_we && (hb_addr == ADDR_W'(OFS_WHI));
  assign sel_wlo = hb_we && (hb_addr == ADDR_W'(OFS_WLO));
  assign sel_ctl = hb_we && (hb_addr == ADDR_W'(OFS_CTL));
  assign sel_evt = hb_we && (hb_addr == ADDR_W'(OFS_EVT));

  swb_own u_own (
    .clk(clk), .rst_n(rstn_i), .ctl_we(sel_ctl),
    .ctl_req_in(hb_wdata[CTL_REQ]), .ctl_ien_in(hb_wdata[CTL_IEN]),
    .init_done(core_init_done),
    .req_q(req_q), .ien_q(ien_q), .grant_q(grant_q)
  );

  swb_xfer #(.TMO_W(TMO_W)) u_xfer (
    .clk(clk), .rst_n(rstn_i), .cmd_we(sel_cmd),
    .cmd_go(hb_wdata[CMD_GO]), .cmd_rst(hb_wdata[CMD_RST]),
    .cmd_wr(hb_wdata[CMD_WR]),
    .cmd_page(hb_wdata[CMD_PAGE0 +: PAGE_W]),
    .cmd_regno(hb_wdata[CMD_REG0 +: REG_W]),
    .grant(grant_q), .sw_ack(sw_ack), .limit(ack_timeout),
    .go_q(go_q), .tmo_q(tmo_q), .rst_q(rst_q), .cmd_q(cmd_q),
    .rd_load(rd_load)
  );

  swb_evt #(.EVT_W(EVT_W)) u_evt (
    .clk(clk), .rst_n(rstn_i), .pulse(evt_in), .clr_we(sel_evt),
    .clr_mask(hb_wdata[EVT_W-1:0]), .ien(ien_q),
    .pend_q(pend_q), .irq(host_irq)
  );

  // data words: next state
  always_comb begin
    whi_d = whi_q;
    wlo_d = wlo_q;
    rhi_d = rhi_q;
    rlo_d = rlo_q;
    if (rst_q) begin
      whi_d = '0;
      wlo_d = '0;
      rhi_d = '0;
      rlo_d = '0;
    end else begin
      if (sel_whi) whi_d = hb_wdata;
      if (sel_wlo) wlo_d = hb_wdata;
      if (rd_load) {rhi_d, rlo_d} = sw_rdata;
    end
  end

  always_ff @(posedge clk or negedge rstn_i) begin
    if (!rstn_i) begin
      whi_q <= '0;
      wlo_q <= '0;
      rhi_q <= '0;
      rlo_q <= '0;
    end else begin
      whi_q <= whi_d;
      wlo_q <= wlo_d;
      rhi_q <= rhi_d;
      rlo_q <= rlo_d;
    end
  end

  assign sw_req   = go_q && !rst_q;
  assign sw_page  = cmd_q.page;
  assign sw_regno = cmd_q.regno;
  assign sw_write = cmd_q.wr;
  assign sw_wdata = {whi_q, wlo_q};

  // host read mux
  always_comb begin
    hb_rdata = '0;
    case (hb_addr)
      ADDR_W'(OFS_CMD): begin
        hb_rdata[CMD_PAGE0 +: PAGE_W] = cmd_q.page;
        hb_rdata[CMD_REG0 +: REG_W]   = cmd_q.regno;
        hb_rdata[CMD_TMO]             = tmo_q;
        hb_rdata[CMD_RST]             = rst_q;
        hb_rdata[CMD_WR]              = cmd_q.wr;
        hb_rdata[CMD_GO]              = go_q;
      end
      ADDR_W'(OFS_WHI): hb_rdata = whi_q;
      ADDR_W'(OFS_WLO): hb_rdata = wlo_q;
      ADDR_W'(OFS_RHI): hb_rdata = rhi_q;
      ADDR_W'(OFS_RLO): hb_rdata = rlo_q;
      ADDR_W'(OFS_CTL): begin
        hb_rdata[CTL_IEN]  = ien_q;
        hb_rdata[CTL_REQ]  = req_q;
        hb_rdata[CTL_GNT]  = grant_q;
        hb_rdata[CTL_INIT] = core_init_done;
      end
      ADDR_W'(OFS_EVT): hb_rdata[EVT_W-1:0] = pend_q;
      default: hb_rdata = '0;
    endcase
  end

  // R3
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rstn_i)
    (!rd_load && !rst_q) |=> $stable({rhi_q, rlo_q}));

  // R1
  req_fields_chk: assert property (@(posedge clk) disable iff (!rstn_i)
    (sw_req && !sw_ack) |=> (!sw_req || $stable({sw_page, sw_regno, sw_write})));

  // R9
  rst_drops_req_chk: assert property (@(posedge clk) disable iff (!rstn_i)
    rst_q |-> !sw_req);
endmodule

// File: tb/swb_bridge_tb.sv
module swb_bridge_tb;
  localparam logic [7:0] A_CMD = 8'h2C, A_WHI = 8'h30, A_WLO = 8'h34;
  localparam logic [7:0] A_RHI = 8'h38, A_RLO = 8'h3C, A_CTL = 8'h40;
  localparam logic [7:0] A_EVT = 8'h44;

  typedef struct {
    logic [7:0]  page;
    logic [7:0]  regno;
    logic        wr;
    logic [63:0] data;
  } sb_item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  hb_addr = '0;
  logic        hb_we = 1'b0;
  logic [31:0] hb_wdata = '0;
  logic [31:0] hb_rdata;
  logic        host_irq, sw_req, sw_write;
  logic [7:0]  sw_page, sw_regno;
  logic [63:0] sw_wdata;
  logic        sw_ack = 1'b0;
  logic [63:0] sw_rdata = '0;
  logic        core_init_done = 1'b1;
  logic [15:0] ack_timeout = 16'd100;
  logic [12:0] evt_in = '0;

  int n_vec = 0, n_bad = 0;
  int ack_dly = 3;
  bit mute = 1'b0;
  int wait_cnt = 0;
  int req_cycles = 0;
  sb_item_t exp_q[$];
  logic [63:0] mem [logic [15:0]];

  always #4 clk = ~clk;

  swb_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .hb_addr(hb_addr), .hb_we(hb_we),
    .hb_wdata(hb_wdata), .hb_rdata(hb_rdata), .host_irq(host_irq),
    .sw_req(sw_req), .sw_page(sw_page), .sw_regno(sw_regno),
    .sw_write(sw_write), .sw_wdata(sw_wdata), .sw_ack(sw_ack),
    .sw_rdata(sw_rdata), .core_init_done(core_init_done),
    .ack_timeout(ack_timeout), .evt_in(evt_in)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  // switch model and scoreboard monitor
  always @(negedge clk) begin
    if (sw_req) req_cycles++;
    if (!rst_n || !sw_req) begin
      wait_cnt = 0;
      sw_ack = 1'b0;
    end else if (sw_ack) begin
      sw_ack = 1'b0;
    end else if (!mute && wait_cnt >= ack_dly) begin
      sb_item_t it;
      n_vec++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R1: unexpected access page %h reg %h", sw_page, sw_regno);
      end else begin
        it = exp_q.pop_front();
        if (sw_page !== it.page || sw_regno !== it.regno || sw_write !== it.wr ||
            (it.wr && sw_wdata !== it.data)) begin
          n_bad++;
          $display("FAIL R1: got %h/%h/%b/%h expected %h/%h/%b/%h",
                   sw_page, sw_regno, sw_write, sw_wdata,
                   it.page, it.regno, it.wr, it.data);
        end
      end
      if (sw_write) mem[{sw_page, sw_regno}] = sw_wdata;
      sw_rdata = mem.exists({sw_page, sw_regno}) ? mem[{sw_page, sw_regno}] : 64'd0;
      sw_ack = 1'b1;
    end else begin
      wait_cnt++;
    end
  end

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    hb_addr = a; hb_wdata = d; hb_we = 1'b1;
    @(negedge clk);
    hb_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    hb_addr = a;
    #1 d = hb_rdata;
  endtask

  task automatic poll_done(output logic [31:0] st);
    for (int i = 0; i < 300; i++) begin
      bus_rd(A_CMD, st);
      if (!st[0]) break;
    end
  endtask

  task automatic push(input logic [7:0] p, input logic [7:0] r, input logic w, input logic [63:0] d);
    sb_item_t it;
    it.page = p; it.regno = r; it.wr = w; it.data = d;
    exp_q.push_back(it);
  endtask

  task automatic pulse(input logic [12:0] m);
    @(negedge clk);
    evt_in = m;
    @(negedge clk);
    evt_in = '0;
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] v;
    mem[16'h0502] = 64'hCAFE_F00D_0000_BEEF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    bus_rd(A_CMD, v); chk("R2 reset cmd", v, 0);
    bus_rd(A_CTL, v); chk("R4 reset ctl", v, 32'h40);
    bus_rd(A_EVT, v); chk("R6 reset evt", v, 0);
    bus_rd(8'h10, v); chk("R10 unmapped", v, 0);
    chk("R7 reset irq", host_irq, 0);

    // no grant: command ignored
    bus_wr(A_CMD, 32'h1122_0001);
    bus_rd(A_CMD, v); chk("R5 no grant", v, 0);
    chk("R5 no req", sw_req, 0);

    // ownership
    bus_wr(A_CTL, 32'h08);
    bus_rd(A_CTL, v); chk("R4 grant", v, 32'h58);

    // 64-bit write
    bus_wr(A_WHI, 32'hDEAD_BEEF);
    bus_wr(A_WLO, 32'h0123_4567);
    push(8'h12, 8'h34, 1'b1, 64'hDEAD_BEEF_0123_4567);
    bus_wr(A_CMD, 32'h1234_0003);
    #1 chk("R1 req up", sw_req, 1);
    poll_done(v); chk("R2 write done", v, 32'h1234_0002);
    bus_rd(A_RLO, v); chk("R3 write keeps rd", v, 0);

    // read back
    push(8'h12, 8'h34, 1'b0, 64'd0);
    bus_wr(A_CMD, 32'h1234_0001);
    poll_done(v); chk("R2 read done", v, 32'h1234_0000);
    bus_rd(A_RHI, v); chk("R3 rd hi", v, 32'hDEAD_BEEF);
    bus_rd(A_RLO, v); chk("R3 rd lo", v, 32'h0123_4567);

    // busy: second command ignored
    ack_dly = 20;
    push(8'h05, 8'h02, 1'b0, 64'd0);
    bus_wr(A_CMD, 32'h0502_0001);
    bus_wr(A_CMD, 32'h7777_0003);
    poll_done(v); chk("R5 busy ignored", v, 32'h0502_0000);
    bus_rd(A_RHI, v); chk("R3 rd hi 2", v, 32'hCAFE_F00D);
    bus_rd(A_RLO, v); chk("R3 rd lo 2", v, 32'h0000_BEEF);
    // write access leaves read data in place
    ack_dly = 2;
    push(8'h06, 8'h01, 1'b1, 64'hDEAD_BEEF_0123_4567);
    bus_wr(A_CMD, 32'h0601_0003);
    poll_done(v);
    bus_rd(A_RLO, v); chk("R3 hold across write", v, 32'h0000_BEEF);

    // timeout
    ack_timeout = 16'd8;
    mute = 1'b1;
    req_cycles = 0;
    bus_wr(A_CMD, 32'h0909_0001);
    poll_done(v); chk("R8 tmo flag", v, 32'h0909_0008);
    chk("R8 req cycles", req_cycles, 8);
    mute = 1'b0;
    ack_timeout = 16'd100;
    push(8'h0A, 8'h0B, 1'b0, 64'd0);
    bus_wr(A_CMD, 32'h0A0B_0001);
    poll_done(v); chk("R8 flag cleared", v, 32'h0A0B_0000);

    // soft reset
    ack_dly = 50;
    bus_wr(A_CMD, 32'h0C0D_0001);
    repeat (3) @(negedge clk);
    bus_wr(A_CMD, 32'h0000_0004);
    bus_rd(A_CMD, v); chk("R9 cmd clear", v, 0);
    chk("R9 req low", sw_req, 0);
    bus_rd(A_WHI, v); chk("R9 whi clear", v, 0);
    bus_rd(A_RLO, v); chk("R9 rlo clear", v, 0);
    ack_dly = 3;

    // interrupts
    pulse(13'h0021);
    pulse(13'h1000);
    bus_rd(A_EVT, v); chk("R6 capture", v, 32'h1021);
    chk("R7 masked", host_irq, 0);
    bus_wr(A_CTL, 32'h0A);
    chk("R7 enabled", host_irq, 1);
    bus_wr(A_EVT, 32'h1);
    bus_rd(A_EVT, v); chk("R6 w1c", v, 32'h1020);
    @(negedge clk);
    hb_addr = A_EVT; hb_wdata = 32'h20; hb_we = 1'b1; evt_in = 13'h0020;
    @(negedge clk);
    hb_we = 1'b0; evt_in = '0;
    bus_rd(A_EVT, v); chk("R6 set wins", v, 32'h1020);
    bus_wr(A_EVT, 32'hFFFF_FFFF);
    bus_rd(A_EVT, v); chk("R6 clear all", v, 0);
    chk("R7 irq off", host_irq, 0);

    // release ownership
    bus_wr(A_CTL, 32'h00);
    bus_rd(A_CTL, v); chk("R4 grant drop", v, 32'h40);
    bus_wr(A_CMD, 32'h0101_0001);
    bus_rd(A_CMD, v); chk("R5 after release", v[0], 0);

    repeat (5) @(negedge clk);
    chk("R1 scoreboard empty", exp_q.size(), 0);
    summary();
  end
endmodule